// File: doc/BRIEF.md
# Next-N-Line Prefetch Generator

This block sits beside a cache and turns each demand line request into a short run of prefetch candidates for the lines that follow it. When a demand for line X is accepted by the memory side, a stepping generator produces X+1, X+2 and so on, one per clock, up to a depth chosen at runtime. It stops early at the last line of the 4 KiB page that holds X. Candidates are not sent at once: they are written into a small first-in first-out prefetch queue.

The block owns the single read-request port toward memory. A waiting demand always takes the port. The queue sends its oldest entry only in a cycle where no demand is presented. A prefetch leaves on the same line-address and valid/ready signals as a demand, so the memory side sees an ordinary read. Addresses are line addresses: with 64-byte lines, the low six bits give the line's place inside its page. Cache storage, fill data and filtering of lines already cached are handled elsewhere.

Top module: `nnl_prefetch_gen`

## Requirements
- R1: A demand for line X is accepted in a cycle where dmd_valid and mem_ready are both high. With depth N (sampled in that cycle) and no page clipping, the prefetches leaving the port are X+1 through X+N in ascending order. With mem_ready high and no further demand, X+1 is presented in the second cycle after the accepting cycle, and one candidate follows in each later cycle.
- R2: No candidate leaves the page of X. The page is line-address bits 6 and up. A demand whose low six bits are F yields at most 63-F candidates, so a demand at offset 63 yields none.
- R3: pf_depth 0 yields no prefetches. Values 9 to 15 act as 8.
- R4: While dmd_valid is high, mem_valid is high, mem_line equals dmd_line, and no queued prefetch is consumed. Queued prefetches leave intact once the demand is gone.
- R5: A prefetch is presented on mem_valid/mem_line only in cycles with dmd_valid low. Queued prefetches leave oldest first.
- R6: dmd_ready always equals mem_ready, so a full queue never stalls demands. Candidates produced while the 4-entry queue is full are dropped, and the entries already queued are kept.
- R7: A newly accepted demand abandons any candidates of the previous demand not yet produced. The cycle of acceptance produces none for the old demand.
- R8: After reset, the queue is empty and mem_valid is low while no demand is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmd_valid | input | 1 | Demand line request present |
| dmd_line | input | 26 | Demand line address |
| dmd_ready | output | 1 | Demand taken by memory side (follows mem_ready) |
| pf_depth | input | 4 | Prefetch depth, 0 disables, clamped to 8 |
| mem_valid | output | 1 | Read request toward memory |
| mem_line | output | 26 | Line address of the read request |
| mem_ready | input | 1 | Memory side accepts the request |

## Verification
A stepping counter or limit left wrong shows at the port within a few cycles of the next demand. It shows as a run that is too short, too long or crosses a page, or as an address off by one in the first candidate after the accepting cycle. A queue pointer or count that is wrong shows as lost, repeated or reordered prefetches the next time the queue drains. A broken priority mux shows as a prefetch address in a cycle with a demand present. The sweep over depth and page offset compares each run's full address list and its start cycle.

// File: rtl/nnl_pkg.sv
package nnl_pkg;
  localparam int unsigned DEF_LINE_W    = 26;
  localparam int unsigned DEF_PAGE_BITS = 6;
  localparam int unsigned DEF_MAX_DEPTH = 8;
  localparam int unsigned DEF_DEPTH_W   = 4;
  localparam int unsigned DEF_Q_DEPTH   = 4;

  // Number of candidates for one demand: depth clamped to max_depth, then
  // limited by the lines left in the page after the demand's offset.
  function automatic int unsigned clip_count(int unsigned depth,
                                             int unsigned offset,
                                             int unsigned max_depth,
                                             int unsigned page_bits);
    int unsigned want;
    int unsigned room;
    want = (depth > max_depth) ? max_depth : depth;
    room = (32'd1 << page_bits) - 32'd1 - offset;
    return (want < room) ? want : room;
  endfunction
endpackage

// File: rtl/nnl_cand_gen.sv
module nnl_cand_gen
  import nnl_pkg::*;
#(
  parameter int unsigned LINE_W    = DEF_LINE_W,
  parameter int unsigned PAGE_BITS = DEF_PAGE_BITS,
  parameter int unsigned MAX_DEPTH = DEF_MAX_DEPTH,
  parameter int unsigned DEPTH_W   = DEF_DEPTH_W,
  localparam int unsigned KW       = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINE_W-1:0] start_line,
  input  logic [DEPTH_W-1:0] start_depth,
  output logic              cand_valid,
  output logic [LINE_W-1:0] cand_line,
  output logic              gen_active,
  output logic [KW-1:0]     gen_k,
  output logic [KW-1:0]     gen_lim,
  output logic [LINE_W-1:0] gen_base
);
  logic [KW-1:0] lim_calc;

  always_comb begin
    lim_calc = KW'(clip_count(32'(start_depth),
                              32'(start_line[PAGE_BITS-1:0]),
                              MAX_DEPTH, PAGE_BITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_active <= 1'b0;
      gen_k      <= '0;
      gen_lim    <= '0;
      gen_base   <= '0;
    end else if (start) begin
      gen_base   <= start_line;
      gen_k      <= KW'(1);
      gen_lim    <= lim_calc;
      gen_active <= (lim_calc != '0);
    end else if (gen_active) begin
      gen_k <= gen_k + KW'(1);
      if (gen_k == gen_lim) gen_active <= 1'b0;
    end
  end

  // A demand accepted this cycle aborts the old run's candidate.
  assign cand_valid = gen_active && !start;
  assign cand_line  = gen_base + LINE_W'(gen_k);
endmodule

// File: rtl/nnl_pf_queue.sv
module nnl_pf_queue #(
  parameter int unsigned W     = 26,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [W-1:0]  push_data,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          nonempty,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic          pop_ok;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PW'(1);
  endfunction

  assign nonempty = (count != '0);
  assign push_ok  = push_req && (count != FULL_CNT);
  assign pop_ok   = pop_req && nonempty;
  assign head     = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/nnl_port_arb.sv
module nnl_port_arb #(
  parameter int unsigned LINE_W = 26
) (
  input  logic              dmd_valid,
  input  logic [LINE_W-1:0] dmd_line,
  input  logic              q_nonempty,
  input  logic [LINE_W-1:0] q_head,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [LINE_W-1:0] mem_line,
  output logic              dmd_ready,
  output logic              dmd_accept,
  output logic              pf_pop
);
  always_comb begin
    mem_valid  = dmd_valid || q_nonempty;
    mem_line   = dmd_valid ? dmd_line : q_head;
    dmd_ready  = mem_ready;
    dmd_accept = dmd_valid && mem_ready;
    pf_pop     = !dmd_valid && mem_ready && q_nonempty;
  end
endmodule

// File: rtl/nnl_prefetch_gen.sv
module nnl_prefetch_gen
  import nnl_pkg::*;
#(
  parameter int unsigned LINE_W    = DEF_LINE_W,
  parameter int unsigned PAGE_BITS = DEF_PAGE_BITS,
  parameter int unsigned MAX_DEPTH = DEF_MAX_DEPTH,
  parameter int unsigned DEPTH_W   = DEF_DEPTH_W,
  parameter int unsigned Q_DEPTH   = DEF_Q_DEPTH,
  localparam int unsigned KW       = $clog2(MAX_DEPTH + 1),
  localparam int unsigned CW       = $clog2(Q_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dmd_valid,
  input  logic [LINE_W-1:0]  dmd_line,
  output logic               dmd_ready,
  input  logic [DEPTH_W-1:0] pf_depth,
  output logic               mem_valid,
  output logic [LINE_W-1:0]  mem_line,
  input  logic               mem_ready
);
  // Named internal events, observed by the bound checker.
  logic              dmd_accept;
  logic              pf_pop;
  logic              cand_valid;
  logic [LINE_W-1:0] cand_line;
  logic              gen_active;
  logic [KW-1:0]     gen_k;
  logic [KW-1:0]     gen_lim;
  logic [LINE_W-1:0] gen_base;
  logic              q_push;
  logic              q_nonempty;
  logic [LINE_W-1:0] q_head;
  logic [CW-1:0]     q_count;

  nnl_cand_gen #(
    .LINE_W(LINE_W), .PAGE_BITS(PAGE_BITS),
    .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n),
    .start(dmd_accept), .start_line(dmd_line), .start_depth(pf_depth),
    .cand_valid(cand_valid), .cand_line(cand_line),
    .gen_active(gen_active), .gen_k(gen_k), .gen_lim(gen_lim),
    .gen_base(gen_base)
  );

  nnl_pf_queue #(.W(LINE_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_req(cand_valid), .push_data(cand_line),
    .pop_req(pf_pop), .push_ok(q_push),
    .nonempty(q_nonempty), .head(q_head), .count(q_count)
  );

  nnl_port_arb #(.LINE_W(LINE_W)) u_arb (
    .dmd_valid(dmd_valid), .dmd_line(dmd_line),
    .q_nonempty(q_nonempty), .q_head(q_head),
    .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_line(mem_line),
    .dmd_ready(dmd_ready), .dmd_accept(dmd_accept), .pf_pop(pf_pop)
  );
endmodule

// File: rtl/nnl_prefetch_chk.sv
module nnl_prefetch_chk #(
  parameter int unsigned LINE_W    = 26,
  parameter int unsigned PAGE_BITS = 6,
  parameter int unsigned MAX_DEPTH = 8,
  parameter int unsigned DEPTH_W   = 4,
  parameter int unsigned Q_DEPTH   = 4,
  localparam int unsigned KW       = $clog2(MAX_DEPTH + 1),
  localparam int unsigned CW       = $clog2(Q_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dmd_valid,
  input logic               dmd_accept,
  input logic [DEPTH_W-1:0] pf_depth,
  input logic               pf_pop,
  input logic               cand_valid,
  input logic [LINE_W-1:0]  cand_line,
  input logic [LINE_W-1:0]  gen_base,
  input logic               gen_active,
  input logic [KW-1:0]      gen_k,
  input logic [KW-1:0]      gen_lim,
  input logic               q_push,
  input logic [CW-1:0]      q_count
);
  localparam logic [CW-1:0] QFULL = CW'(Q_DEPTH);
  localparam logic [KW-1:0] KMAX  = KW'(MAX_DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QFULL); // R6

  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == QFULL && !pf_pop) |=> q_count == QFULL); // R6

  AST_CAND_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> cand_line[LINE_W-1:PAGE_BITS] == gen_base[LINE_W-1:PAGE_BITS]); // R2

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    gen_active |-> (gen_k != '0 && gen_k <= gen_lim && gen_lim <= KMAX)); // R1

  AST_ZERO_DEPTH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dmd_accept && pf_depth == '0) |=> !gen_active); // R3

  AST_DEMAND_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    (dmd_valid && !q_push) |=> q_count >= $past(q_count)); // R4

  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    dmd_accept |=> (!gen_active || gen_k == KW'(1))); // R7
endmodule

bind nnl_prefetch_gen nnl_prefetch_chk #(
  .LINE_W(LINE_W), .PAGE_BITS(PAGE_BITS), .MAX_DEPTH(MAX_DEPTH),
  .DEPTH_W(DEPTH_W), .Q_DEPTH(Q_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_accept(dmd_accept),
  .pf_depth(pf_depth), .pf_pop(pf_pop), .cand_valid(cand_valid),
  .cand_line(cand_line), .gen_base(gen_base), .gen_active(gen_active),
  .gen_k(gen_k), .gen_lim(gen_lim), .q_push(q_push), .q_count(q_count)
);

// File: tb/tb_nnl_prefetch_gen.sv
`timescale 1ns/1ps
module tb_nnl_prefetch_gen;
  localparam int LW = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dmd_valid = 1'b0;
  logic [LW-1:0] dmd_line = '0;
  logic          dmd_ready;
  logic [3:0]    pf_depth = '0;
  logic          mem_valid;
  logic [LW-1:0] mem_line;
  logic          mem_ready = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit col = 1'b0;
  logic [LW-1:0] got[$];
  int got_cyc[$];

  always #5 clk = ~clk;

  nnl_prefetch_gen dut (
    .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_line(dmd_line),
    .dmd_ready(dmd_ready), .pf_depth(pf_depth), .mem_valid(mem_valid),
    .mem_line(mem_line), .mem_ready(mem_ready)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Record every prefetch handshake (port busy with no demand present).
  always @(negedge clk) begin
    if (col && mem_valid && mem_ready && !dmd_valid) begin
      got.push_back(mem_line);
      got_cyc.push_back(cyc);
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(bit v, logic [LW-1:0] l, int d, bit r);
    @(posedge clk); #1;
    dmd_valid = v; dmd_line = l; pf_depth = 4'(d); mem_ready = r;
  endtask

  task automatic check_run(logic [LW-1:0] base, int n, string tag);
    bit ok = 1'b1;
    chk(got.size() == n, tag, got.size(), n);
    for (int i = 0; i < got.size() && i < n; i++)
      if (got[i] != LW'(base + LW'(i + 1))) ok = 1'b0;
    chk(ok, tag, (got.size() > 0) ? got[0] : 0, base + 1);
  endtask

  task automatic sweep_one(int d, int off, int pg);
    logic [LW-1:0] base;
    int want, n, acc;
    string tag;
    bit contig;
    base = {20'(pg), 6'(off)};
    want = (d > 8) ? 8 : d;
    n = (want < 63 - off) ? want : 63 - off;
    if (d == 0 || d > 8) tag = "R3";
    else if (n < want) tag = "R2";
    else tag = "R1";
    got.delete(); got_cyc.delete(); col = 1'b1;
    drive(1'b1, base, d, 1'b1);
    drive(1'b0, '0, d, 1'b1);
    acc = cyc;
    repeat (14) @(posedge clk);
    @(negedge clk); col = 1'b0;
    check_run(base, n, tag);
    if (n > 0) begin
      chk(got_cyc[0] == acc + 1, "R1 start cycle", got_cyc[0], acc + 1);
      contig = 1'b1;
      for (int i = 1; i < got_cyc.size(); i++)
        if (got_cyc[i] != got_cyc[i-1] + 1) contig = 1'b0;
      chk(contig, "R1 one per cycle", contig, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=finished", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [LW-1:0] xa, ya, aa, ba;
    int offs[8] = '{0, 1, 30, 55, 56, 57, 62, 63};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mem_ready = 1'b1;
    @(negedge clk);
    // R8: empty queue, no request after reset
    chk(mem_valid == 1'b0, "R8 reset idle", mem_valid, 0);
    chk(dmd_ready == 1'b1, "R6 ready follows", dmd_ready, 1);

    // R1/R2/R3 sweep over depth and page offset
    for (int d = 0; d <= 10; d++)
      for (int k = 0; k < 8; k++)
        sweep_one((d == 10) ? 15 : d, offs[k], 16'h5A0 + d * 8 + k);

    // R4/R6: fill queue with port stalled, then demand takes the port
    xa = {20'h00777, 6'd10};
    ya = {20'h00999, 6'd3};
    got.delete(); col = 1'b0;
    drive(1'b1, xa, 8, 1'b1);
    drive(1'b0, '0, 8, 1'b0);
    repeat (12) drive(1'b0, '0, 8, 1'b0);
    @(negedge clk);
    chk(mem_valid && mem_line == xa + 1, "R5 oldest at head", mem_line, xa + 1);
    drive(1'b1, ya, 0, 1'b1);
    col = 1'b1;
    @(negedge clk);
    chk(mem_valid == 1'b1, "R4 demand valid", mem_valid, 1);
    chk(mem_line == ya, "R4 demand wins", mem_line, ya);
    chk(dmd_ready == 1'b1, "R6 demand not stalled", dmd_ready, 1);
    drive(1'b0, '0, 0, 1'b1);
    repeat (8) @(posedge clk);
    @(negedge clk); col = 1'b0;
    check_run(xa, 4, "R6 drop keeps oldest");

    // R7: second demand right after the first aborts the first run
    aa = {20'h00123, 6'd0};
    ba = {20'h00456, 6'd20};
    got.delete(); col = 1'b1;
    drive(1'b1, aa, 8, 1'b1);
    drive(1'b1, ba, 3, 1'b1);
    drive(1'b0, '0, 3, 1'b1);
    repeat (14) @(posedge clk);
    @(negedge clk); col = 1'b0;
    check_run(ba, 3, "R7 abort");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule